// File: doc/BRIEF.md
# Serial Audio Link Output Framer

This block is the controller-side transmitter of a serial audio link. It runs entirely on the bit clock that the codec supplies. A 256-count divider on that clock defines the frame. A frame-start marker is raised for the opening tag phase of each frame. Every frame is then shifted out one bit per clock, most significant bit first. It carries a 16-bit tag slot followed by twelve 20-bit data slots.

The sample source and the register-access logic hand over their data through single-cycle strobes. Each strobe captures a pending value. At the next frame boundary the pending values are frozen into the outgoing frame, so one frame never mixes old and new data. The tag slot is built from the flags of what was pending. Any slot without valid content is sent as all zeros. The sample source is told through a one-cycle handshake when its samples have gone into a frame.

Top module: `sal_tx_framer`

## Requirements
- R1: While `rst` is high, `ser_out`, `frame_mark` and `pcm_taken` are 0.
- R2: Bit 0 of the first frame appears after the first rising clock edge following reset release. Every frame is 256 clocks long. `frame_mark` is high exactly while bits 0 to 15 of a frame are on `ser_out`.
- R3: Frame bit 0 is 1 exactly when at least one of slots 1 to 12 is tagged valid in that frame.
- R4: Frame bits 1 to 12 are the valid tags of slots 1 to 12 in that order. Frame bits 13 to 15 are 0.
- R5: A pending command tags slot 1 (frame bits 16 to 35). Sent most significant bit first, slot 1 holds the read flag (1 = read, 0 = write), then the 7-bit address with its most significant bit first, then 12 zeros.
- R6: Slot 2 (frame bits 36 to 55) is tagged only for a pending write command. It holds the 16-bit write data, most significant bit first, then 4 zeros. A read command leaves slot 2 untagged.
- R7: A pending left sample tags slot 3 (frame bits 56 to 75). A pending right sample tags slot 4 (frame bits 76 to 95). Each holds its 16-bit sample left-justified, followed by 4 zeros.
- R8: Every bit of an untagged slot is 0, and slots 5 to 12 are always untagged.
- R9: A strobe sampled on any edge other than a frame-start edge is used in the next frame. A strobe sampled on the frame-start edge (the edge at which `frame_mark` rises) is used in the frame after that. A later strobe overwrites an earlier one that has not yet been used. Each pending item is sent in one frame only.
- R10: `pcm_taken` is high for exactly the one clock in which bit 0 of a frame is on `ser_out`, and only when that frame tags slot 3 or slot 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the codec |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Captures a register command |
| cmd_read | input | 1 | 1 = read command, 0 = write command |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 16 | Register write data |
| left_stb | input | 1 | Captures a left playback sample |
| left_smp | input | 16 | Left playback sample |
| right_stb | input | 1 | Captures a right playback sample |
| right_smp | input | 16 | Right playback sample |
| frame_mark | output | 1 | High during the tag phase of each frame |
| ser_out | output | 1 | Serial frame data, changes on rising edges |
| pcm_taken | output | 1 | Pulse: pending samples entered the current frame |

## Verification
The collision that matters is a capture strobe and the frame-boundary load falling on the same edge. On that edge the pending flag is cleared by the load and set again by the strobe. The bench provokes it by driving strobes exactly one clock before `frame_mark` rises. The cycle-accurate model then expects the old contents in the frame now starting and the new value in the following frame. The bench also repeats strobes inside one frame to confirm that the newest value overwrites the earlier one, and sends read and write commands back to back to exercise the slot 2 tag rule.

// File: rtl/sal_pkg.sv
package sal_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int FRAME_LEN = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int POS_W     = $clog2(FRAME_LEN);
endpackage

// File: rtl/sal_bit_counter.sv
module sal_bit_counter
  import sal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic             at_end,
  output logic             mark
);
  localparam logic [POS_W-1:0] LAST    = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] TAG_TOP = POS_W'(TAG_W - 1);

  assign at_end = (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= LAST;
      mark <= 1'b0;
    end else begin
      pos  <= at_end ? '0 : pos + 1'b1;
      mark <= at_end || (pos < TAG_TOP);
    end
  end

  // R2
  mark_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mark) |-> (pos == '0));

  // R2
  mark_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mark) |-> (pos == POS_W'(TAG_W)));
endmodule

// File: rtl/sal_slot_pack.sv
module sal_slot_pack
  import sal_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SMP_W  = 16
) (
  input  logic                 cmd_ok,
  input  logic                 cmd_rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [SMP_W-1:0]     wdata,
  input  logic                 left_ok,
  input  logic [SMP_W-1:0]     left,
  input  logic                 right_ok,
  input  logic [SMP_W-1:0]     right,
  output logic [FRAME_LEN-1:0] image
);
  localparam int ADDR_PAD = SLOT_W - 1 - ADDR_W;
  localparam int SMP_PAD  = SLOT_W - SMP_W;

  logic [NUM_SLOTS-1:0]  tag;
  logic [SLOT_W-1:0]     val [NUM_SLOTS];

  always_comb begin
    tag    = '0;
    tag[0] = cmd_ok;
    tag[1] = cmd_ok && !cmd_rd;
    tag[2] = left_ok;
    tag[3] = right_ok;
  end

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s == 0) begin : g_cmd
        assign val[s] = {cmd_rd, addr, {ADDR_PAD{1'b0}}};
      end else if (s == 1) begin : g_dat
        assign val[s] = {wdata, {SMP_PAD{1'b0}}};
      end else if (s == 2) begin : g_left
        assign val[s] = {left, {SMP_PAD{1'b0}}};
      end else if (s == 3) begin : g_right
        assign val[s] = {right, {SMP_PAD{1'b0}}};
      end else begin : g_idle
        assign val[s] = '0;
      end
      assign image[FRAME_LEN-1-TAG_W-SLOT_W*s -: SLOT_W] = tag[s] ? val[s] : '0;
      assign image[FRAME_LEN-2-s] = tag[s];
    end
  endgenerate

  assign image[FRAME_LEN-1] = |tag;
  assign image[FRAME_LEN-2-NUM_SLOTS -: TAG_W-1-NUM_SLOTS] = '0;
endmodule

// File: rtl/sal_tx_framer.sv
module sal_tx_framer
  import sal_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SMP_W-1:0]  cmd_wdata,
  input  logic              left_stb,
  input  logic [SMP_W-1:0]  left_smp,
  input  logic              right_stb,
  input  logic [SMP_W-1:0]  right_smp,
  output logic              frame_mark,
  output logic              ser_out,
  output logic              pcm_taken
);
  localparam logic [POS_W-1:0] TAG_FREE = POS_W'(NUM_SLOTS + 1);
  localparam logic [POS_W-1:0] TAG_TOP  = POS_W'(TAG_W - 1);
  localparam logic [POS_W-1:0] IDLE_LO  = POS_W'(TAG_W + 4 * SLOT_W);

  logic [POS_W-1:0]     pos;
  logic                 load;
  logic [FRAME_LEN-1:0] image;
  logic [FRAME_LEN-2:0] shreg;

  logic              p_cmd, p_rd, p_left, p_right;
  logic [ADDR_W-1:0] p_addr;
  logic [SMP_W-1:0]  p_wdata, p_lsmp, p_rsmp;

  sal_bit_counter u_cnt (
    .clk    (clk),
    .rst    (rst),
    .pos    (pos),
    .at_end (load),
    .mark   (frame_mark)
  );

  sal_slot_pack #(.ADDR_W(ADDR_W), .SMP_W(SMP_W)) u_pack (
    .cmd_ok   (p_cmd),
    .cmd_rd   (p_rd),
    .addr     (p_addr),
    .wdata    (p_wdata),
    .left_ok  (p_left),
    .left     (p_lsmp),
    .right_ok (p_right),
    .right    (p_rsmp),
    .image    (image)
  );

  // pending stores: a strobe wins over the boundary clear
  always_ff @(posedge clk) begin
    if (rst) begin
      p_cmd   <= 1'b0;
      p_left  <= 1'b0;
      p_right <= 1'b0;
      p_rd    <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
      p_lsmp  <= '0;
      p_rsmp  <= '0;
    end else begin
      p_cmd   <= cmd_stb   || (p_cmd   && !load);
      p_left  <= left_stb  || (p_left  && !load);
      p_right <= right_stb || (p_right && !load);
      if (cmd_stb) begin
        p_rd    <= cmd_read;
        p_addr  <= cmd_addr;
        p_wdata <= cmd_wdata;
      end
      if (left_stb)  p_lsmp <= left_smp;
      if (right_stb) p_rsmp <= right_smp;
    end
  end

  // frame shifter, most significant bit first
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      ser_out   <= 1'b0;
      pcm_taken <= 1'b0;
    end else if (load) begin
      ser_out   <= image[FRAME_LEN-1];
      shreg     <= image[FRAME_LEN-2:0];
      pcm_taken <= p_left || p_right;
    end else begin
      ser_out   <= shreg[FRAME_LEN-2];
      shreg     <= {shreg[FRAME_LEN-3:0], 1'b0};
      pcm_taken <= 1'b0;
    end
  end

  // R10
  taken_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    pcm_taken |-> (frame_mark && pos == '0));

  // R4
  tag_spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pos >= TAG_FREE && pos <= TAG_TOP) |-> !ser_out);

  // R8
  idle_slots_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pos >= IDLE_LO) |-> !ser_out);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ser_out && !frame_mark && !pcm_taken));
endmodule

// File: tb/tb_sal_tx_framer.sv
module tb_sal_tx_framer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LEN = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_stb = 0, cmd_read = 0, left_stb = 0, right_stb = 0;
  logic [6:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0, left_smp = '0, right_smp = '0;
  logic frame_mark, ser_out, pcm_taken;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  sal_tx_framer dut (
    .clk(clk), .rst(rst),
    .cmd_stb(cmd_stb), .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .left_stb(left_stb), .left_smp(left_smp), .right_stb(right_stb), .right_smp(right_smp),
    .frame_mark(frame_mark), .ser_out(ser_out), .pcm_taken(pcm_taken)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int pos = LEN - 1;
  bit frm [LEN];
  bit m_cmd, m_rd, m_l, m_r;
  logic [6:0]  m_addr;
  logic [15:0] m_wd, m_ls, m_rs;
  bit e_ser, e_mark, e_taken;

  function automatic void put_slot(int s, logic [19:0] v);
    for (int k = 0; k < 20; k++) frm[16 + 20*(s-1) + k] = v[19-k];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pos = LEN - 1; m_cmd = 0; m_l = 0; m_r = 0;
      e_ser = 0; e_mark = 0; e_taken = 0;
      foreach (frm[i]) frm[i] = 0;
    end else begin
      bit boundary;
      boundary = (pos == LEN - 1);
      pos = (pos + 1) % LEN;
      e_taken = 0;
      if (boundary) begin
        bit t [13];
        foreach (frm[i]) frm[i] = 0;
        foreach (t[i]) t[i] = 0;
        t[1] = m_cmd; t[2] = m_cmd && !m_rd; t[3] = m_l; t[4] = m_r;
        for (int s = 1; s <= 12; s++) begin
          frm[s] = t[s];
          if (t[s]) frm[0] = 1;
        end
        if (t[1]) put_slot(1, {m_rd, m_addr, 12'h000});
        if (t[2]) put_slot(2, {m_wd, 4'h0});
        if (t[3]) put_slot(3, {m_ls, 4'h0});
        if (t[4]) put_slot(4, {m_rs, 4'h0});
        e_taken = m_l || m_r;
        m_cmd = 0; m_l = 0; m_r = 0;
      end
      if (cmd_stb)   begin m_cmd = 1; m_rd = cmd_read; m_addr = cmd_addr; m_wd = cmd_wdata; end
      if (left_stb)  begin m_l = 1; m_ls = left_smp; end
      if (right_stb) begin m_r = 1; m_rs = right_smp; end
      e_ser = frm[pos];
      e_mark = (pos < 16);
    end
  end

  function automatic string ser_req(int p);
    if (p == 0)  return "R3";
    if (p < 16)  return "R4";
    if (p < 36)  return "R5";
    if (p < 56)  return "R6";
    if (p < 96)  return "R7";
    return "R8";
  endfunction

  always @(negedge clk) if (!done) begin
    string rq;
    vectors++;
    if (rst) begin
      if (ser_out !== 0 || frame_mark !== 0 || pcm_taken !== 0) begin
        fails++;
        $display("FAIL R1 reset outputs ser=%b mark=%b taken=%b expected 0 0 0",
                 ser_out, frame_mark, pcm_taken);
      end
    end else begin
      if (frame_mark !== e_mark) begin
        fails++;
        $display("FAIL R2 frame_mark at bit %0d: got %b expected %b", pos, frame_mark, e_mark);
      end
      if (pcm_taken !== e_taken) begin
        fails++;
        $display("FAIL R10 pcm_taken at bit %0d: got %b expected %b", pos, pcm_taken, e_taken);
      end
      if (ser_out !== e_ser) begin
        rq = ser_req(pos);
        fails++;
        $display("FAIL %s (R9 latching) ser_out at bit %0d: got %b expected %b",
                 rq, pos, ser_out, e_ser);
      end
    end
  end

  task automatic wait_pos(int p);
    while (pos != p) @(negedge clk);
  endtask

  task automatic send_cmd(bit rd, logic [6:0] a, logic [15:0] d);
    cmd_stb = 1; cmd_read = rd; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_stb = 0;
  endtask

  task automatic send_pcm(bit l, bit r, logic [15:0] lv, logic [15:0] rv);
    left_stb = l; right_stb = r; left_smp = lv; right_smp = rv;
    @(negedge clk);
    left_stb = 0; right_stb = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    // idle frame: R3 frame bit 0 low, R8 all zero
    wait_pos(100);
    // R5 R6 R7: write command plus both samples
    send_cmd(0, 7'h2A, 16'hBEEF);
    send_pcm(1, 1, 16'h8001, 16'h7FFE);
    wait_pos(40);
    // R6: read command leaves slot 2 untagged; R7 left only
    send_cmd(1, 7'h55, 16'hFFFF);
    send_pcm(1, 0, 16'hA5C3, 16'h0000);
    wait_pos(200);
    // R9: overwrite before boundary
    send_pcm(0, 1, 16'h0000, 16'h1111);
    send_pcm(0, 1, 16'h0000, 16'h2222);
    send_cmd(0, 7'h7F, 16'h0F0F);
    send_cmd(0, 7'h01, 16'hF0F0);
    // R9: strobe on the frame-start edge goes to the frame after
    wait_pos(LEN - 1);
    send_cmd(1, 7'h11, 16'h1234);
    send_pcm(1, 1, 16'hCAFE, 16'h3C3C);
    // R9: each item sent once, next frame empty
    wait_pos(128);
    wait_pos(LEN - 1);
    send_pcm(0, 1, 16'h0000, 16'hFFFF);
    wait_pos(10);
    wait_pos(LEN - 1);
    // R1: reset mid-frame
    wait_pos(60);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    send_pcm(1, 1, 16'hFFFF, 16'h0001);
    wait_pos(LEN - 1);
    wait_pos(120);
    wait_pos(LEN - 1);
    wait_pos(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule